// File: doc/BRIEF.md
# SDRAM Power and Command Control

This block holds the control word that governs an SDRAM device's power state and its start-up command sequence. Software writes a single control word to steer the clock-enable pin, gate the memory clock, move the device into or out of self-refresh, and step through the start-up commands one at a time. The block turns those settings, together with a busy flag from the transaction engine and an acknowledge from the refresh logic, into the clock-enable level, a clock-gate enable, a self-refresh request and a one-cycle command strobe.

The clock-enable pin and the memory clock are normally gated for power saving: they are active only while an access is in flight and the device is out of self-refresh. Separate force bits keep either one running, and a stop bit shuts the clock off outright. The self-refresh mode actually in effect is tracked separately from the request and changes only when the refresh logic acknowledges. Each write that moves the command field to a new non-normal code emits one strobe carrying that code.

Top module: `sdram_pwr_ctl`

## Requirements
- R1: After reset the control word reads 0x00000006 (clock forced on, self-refresh requested, all else 0), the status word reads 1, srefReq and srefActive are 1 and cmdValid is 0.
- R2: Control bit 0 forces the clock enable: when 1, sdCke is 1; when 0, sdCke equals xferBusy AND NOT srefActive.
- R3: With control bit 5 at 0, control bit 1 set makes sdClkEn 1; bit 1 clear makes sdClkEn equal xferBusy AND NOT srefActive.
- R4: Control bit 5 set holds sdClkEn at 0 whatever the other bits and inputs are.
- R5: Control bit 2 is the self-refresh request; srefReq shows its value from the cycle after the write.
- R6: srefActive (also readable as bit 0 at byte offset CTRL_OFFSET+4) takes the value of the request in the cycle after a cycle with srefAck high, and holds otherwise.
- R7: A control write whose bits 8:7 differ from the stored field and are non-zero (11 NOP, 10 precharge-all, 01 load-mode; 00 normal) raises cmdValid for exactly the next cycle with cmdCode equal to the written code; writing 00 or the unchanged code raises no strobe.
- R8: A control write made while srefActive is 1 raises no strobe, though the field is still stored.
- R9: Bits 4:3, 6 and 31:9 of the control word read 0 regardless of writes; reads of any offset other than the two words return 0, and writes to other offsets change nothing.
- R10: A read at CTRL_OFFSET returns the stored bits 0, 1, 2, 5 and 8:7 combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr |
| xferBusy | input | 1 | Transaction engine has an access in flight |
| srefAck | input | 1 | Refresh logic accepts the current request |
| sdCke | output | 1 | SDRAM clock enable |
| sdClkEn | output | 1 | Enable for the SDRAM clock gate |
| srefReq | output | 1 | Self-refresh request to the refresh logic |
| srefActive | output | 1 | Self-refresh mode in effect |
| cmdValid | output | 1 | One-cycle command strobe |
| cmdCode | output | 2 | Command code carried by the strobe |

## Verification
The bench builds the block with its defaults, an 8-bit offset and the control word at 0x20, so the status word at 0x24 and every other offset of the 256-byte space fall inside the random address draw. That lets stray writes and reads at unmapped offsets, reserved bits, repeated command codes and acknowledges arriving at arbitrary moments all meet a reference model cycle by cycle, while directed steps walk the start-up order and the clock-stop override.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;

  typedef enum logic [1:0] {
    CMD_NORMAL = 2'b00,
    CMD_MODE   = 2'b01,
    CMD_PALL   = 2'b10,
    CMD_NOP    = 2'b11
  } sdCmdE;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCtrl;
    logic fireCmd;
  } ctlStrobeT;

  localparam int BIT_FCKE  = 0;
  localparam int BIT_FCLK  = 1;
  localparam int BIT_SREF  = 2;
  localparam int BIT_CSTOP = 5;
  localparam int CMD_LO    = 7;
  localparam int CMD_HI    = 8;

endpackage

// File: rtl/sdram_pwr_ctrl.sv
module sdram_pwr_ctrl
  import sdram_pwr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 'h20
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        wrCode,
  input  logic [1:0]        curCode,
  input  logic              srefActive,
  output ctlStrobeT         strobe
);

  logic hitCtrl;
  logic codeMoves;

  assign hitCtrl   = regWrEn && (regAddr == CTRL_OFFSET);
  assign codeMoves = (wrCode != curCode) && (sdCmdE'(wrCode) != CMD_NORMAL);

  always_comb begin
    strobe         = '0;
    strobe.wrCtrl  = hitCtrl;
    strobe.fireCmd = hitCtrl && codeMoves && !srefActive;
  end

endmodule

// File: rtl/sdram_pwr_dp.sv
module sdram_pwr_dp
  import sdram_pwr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 'h20,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = 'h24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         strobe,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              xferBusy,
  input  logic              srefAck,
  output logic [DATA_W-1:0] regRdData,
  output logic              sdCke,
  output logic              sdClkEn,
  output logic              srefReq,
  output logic              srefActive,
  output logic              cmdValid,
  output logic [1:0]        cmdCode
);

  logic       forceCke, forceClk, srefBit, clkStop;
  logic [1:0] cmdField;
  logic       activeQ, validQ;
  logic       gatedOn;
  logic       unusedWr;

  assign unusedWr = ^{regWrData[DATA_W-1:CMD_HI+1], regWrData[6], regWrData[4:3]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      forceCke <= 1'b0;
      forceClk <= 1'b1;
      srefBit  <= 1'b1;
      clkStop  <= 1'b0;
      cmdField <= CMD_NORMAL;
      activeQ  <= 1'b1;
      validQ   <= 1'b0;
    end else begin
      if (strobe.wrCtrl) begin
        forceCke <= regWrData[BIT_FCKE];
        forceClk <= regWrData[BIT_FCLK];
        srefBit  <= regWrData[BIT_SREF];
        clkStop  <= regWrData[BIT_CSTOP];
        cmdField <= regWrData[CMD_HI:CMD_LO];
      end
      if (srefAck) activeQ <= srefBit;
      validQ <= strobe.fireCmd;
    end
  end

  assign gatedOn    = xferBusy && !activeQ;
  assign sdCke      = forceCke || gatedOn;
  assign sdClkEn    = !clkStop && (forceClk || gatedOn);
  assign srefReq    = srefBit;
  assign srefActive = activeQ;
  assign cmdValid   = validQ;
  assign cmdCode    = cmdField;

  always_comb begin
    regRdData = '0;
    if (regAddr == CTRL_OFFSET) begin
      regRdData[BIT_FCKE]      = forceCke;
      regRdData[BIT_FCLK]      = forceClk;
      regRdData[BIT_SREF]      = srefBit;
      regRdData[BIT_CSTOP]     = clkStop;
      regRdData[CMD_HI:CMD_LO] = cmdField;
    end else if (regAddr == STAT_OFFSET) begin
      regRdData[0] = activeQ;
    end
  end

endmodule

// File: rtl/sdram_pwr_ctl.sv
module sdram_pwr_ctl
  import sdram_pwr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              xferBusy,
  input  logic              srefAck,
  output logic              sdCke,
  output logic              sdClkEn,
  output logic              srefReq,
  output logic              srefActive,
  output logic              cmdValid,
  output logic [1:0]        cmdCode
);

  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] STAT_OFFSET = CTRL_OFFSET + ADDR_W'(4);

  ctlStrobeT strobe;
  logic [1:0] curCode;

  assign curCode = cmdCode;

  sdram_pwr_ctrl #(.ADDR_W(ADDR_W), .CTRL_OFFSET(CTRL_OFFSET)) uCtrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .wrCode    (regWrData[CMD_HI:CMD_LO]),
    .curCode   (curCode),
    .srefActive(srefActive),
    .strobe    (strobe)
  );

  sdram_pwr_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .CTRL_OFFSET(CTRL_OFFSET), .STAT_OFFSET(STAT_OFFSET)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrData (regWrData),
    .regAddr   (regAddr),
    .xferBusy  (xferBusy),
    .srefAck   (srefAck),
    .regRdData (regRdData),
    .sdCke     (sdCke),
    .sdClkEn   (sdClkEn),
    .srefReq   (srefReq),
    .srefActive(srefActive),
    .cmdValid  (cmdValid),
    .cmdCode   (cmdCode)
  );

endmodule

// File: rtl/sdram_pwr_chk.sv
module sdram_pwr_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 'h20
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regRdData,
  input logic              xferBusy,
  input logic              srefAck,
  input logic              sdCke,
  input logic              sdClkEn,
  input logic              srefActive,
  input logic              cmdValid,
  input logic [1:0]        cmdCode
);

  assert_strobe_needs_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ($past(regWrEn) && $past(regAddr) == CTRL_OFFSET && cmdCode != 2'b00));

  assert_no_cmd_in_sref_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !$past(srefActive));

  assert_status_needs_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(srefAck) |-> (srefActive == $past(srefActive)));

  assert_clock_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == CTRL_OFFSET && regRdData[5]) |-> !sdClkEn);

  assert_cke_low_in_sref_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == CTRL_OFFSET && !regRdData[0] && (srefActive || !xferBusy)) |-> !sdCke);

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == CTRL_OFFSET) |-> (regRdData[4:3] == 2'b00 && !regRdData[6] && regRdData[31:9] == '0));

endmodule

bind sdram_pwr_ctl sdram_pwr_chk #(.ADDR_W(ADDR_W), .CTRL_OFFSET(CTRL_OFFSET)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regRdData(regRdData),
  .xferBusy(xferBusy), .srefAck(srefAck), .sdCke(sdCke), .sdClkEn(sdClkEn),
  .srefActive(srefActive), .cmdValid(cmdValid), .cmdCode(cmdCode)
);

// File: tb/sim_sdram_pwr_ctl.sv
module sim_sdram_pwr_ctl;

  localparam logic [7:0] CTRL = 8'h20;
  localparam logic [7:0] STAT = 8'h24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic xferBusy = 1'b0;
  logic srefAck = 1'b0;
  logic [31:0] regRdData;
  logic sdCke, sdClkEn, srefReq, srefActive, cmdValid;
  logic [1:0] cmdCode;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sdram_pwr_ctl u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .xferBusy(xferBusy),
    .srefAck(srefAck), .sdCke(sdCke), .sdClkEn(sdClkEn), .srefReq(srefReq),
    .srefActive(srefActive), .cmdValid(cmdValid), .cmdCode(cmdCode)
  );

  // reference model
  logic mFcke, mFclk, mSref, mStop, mAct, mValid;
  logic [1:0] mCmd;

  always @(posedge clk) begin
    if (!rstN) begin
      mFcke <= 0; mFclk <= 1; mSref <= 1; mStop <= 0; mCmd <= 2'b00;
      mAct <= 1; mValid <= 0;
    end else begin
      mValid <= 0;
      if (regWrEn && regAddr == CTRL) begin
        mFcke <= regWrData[0]; mFclk <= regWrData[1]; mSref <= regWrData[2];
        mStop <= regWrData[5]; mCmd <= regWrData[8:7];
        mValid <= (regWrData[8:7] != 2'b00) && (regWrData[8:7] != mCmd) && !mAct;
      end
      if (srefAck) mAct <= mSref;
    end
  end

  function automatic logic [31:0] expRd(input logic [7:0] a);
    if (a == CTRL) return {23'b0, mCmd, 1'b0, mStop, 2'b00, mSref, mFclk, mFcke};
    if (a == STAT) return {31'b0, mAct};
    return 32'b0;
  endfunction

  function automatic logic expCke();
    return mFcke || (xferBusy && !mAct);
  endfunction

  function automatic logic expClk();
    return !mStop && (mFclk || (xferBusy && !mAct));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk("R2 sdCke", 32'(sdCke), 32'(expCke()));
    chk(mStop ? "R4 sdClkEn" : "R3 sdClkEn", 32'(sdClkEn), 32'(expClk()));
    chk("R5 srefReq", 32'(srefReq), 32'(mSref));
    chk("R6 srefActive", 32'(srefActive), 32'(mAct));
    chk(mAct ? "R8 cmdValid" : "R7 cmdValid", 32'(cmdValid), 32'(mValid));
    if (mValid) chk("R7 cmdCode", 32'(cmdCode), 32'(mCmd));
    chk((regAddr == CTRL) ? "R10 R9 regRdData" : "R9 regRdData", regRdData, expRd(regAddr));
  endtask

  // one cycle: check current outputs at falling edge, then drive next inputs
  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic b, input logic k);
    @(negedge clk);
    checkAll();
    regWrEn = w; regAddr = a; regWrData = d; xferBusy = b; srefAck = k;
  endtask

  function automatic logic [31:0] ctlWord(input logic [1:0] c, input logic stop,
      input logic sr, input logic fclk, input logic fcke);
    return {23'b0, c, 1'b0, stop, 2'b00, sr, fclk, fcke};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    regAddr = CTRL;
    #1;
    // R1 reset state
    chk("R1 ctrl word", regRdData, 32'h6);
    chk("R1 srefActive", 32'(srefActive), 32'd1);
    chk("R1 srefReq", 32'(srefReq), 32'd1);
    chk("R1 cmdValid", 32'(cmdValid), 32'd0);
    regAddr = STAT;
    #1;
    chk("R1 status word", regRdData, 32'h1);
    @(negedge clk);
    rstN = 1'b1;

    // R8: command written while still in self-refresh
    step(1, CTRL, ctlWord(2'b11, 0, 1, 1, 1), 0, 0);
    step(0, CTRL, 0, 0, 0);
    // R6: leave self-refresh, no ack for a while
    step(1, CTRL, ctlWord(2'b00, 0, 0, 1, 1), 1, 0);
    step(0, STAT, 0, 1, 0);
    step(0, STAT, 0, 1, 1);
    step(0, STAT, 0, 1, 0);
    // R7: start-up order NOP, precharge-all, load-mode, normal
    step(1, CTRL, ctlWord(2'b11, 0, 0, 1, 1), 0, 0);
    step(1, CTRL, ctlWord(2'b10, 0, 0, 1, 1), 0, 0);
    step(1, CTRL, ctlWord(2'b10, 0, 0, 1, 1), 0, 0);
    step(1, CTRL, ctlWord(2'b01, 0, 0, 1, 1), 0, 0);
    step(1, CTRL, ctlWord(2'b00, 0, 0, 0, 0), 1, 0);
    step(0, CTRL, 0, 0, 0);
    // R4: clock stop overrides force clock
    step(1, CTRL, ctlWord(2'b00, 1, 0, 1, 0), 1, 0);
    step(0, CTRL, 0, 1, 0);
    // R9: reserved bits and stray write
    step(1, CTRL, 32'hFFFF_FE58 & ~32'h0000_0180, 0, 0);
    step(1, 8'h40, 32'hFFFF_FFFF, 0, 0);
    step(0, 8'h40, 0, 0, 0);
    step(0, CTRL, 0, 0, 0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [7:0] a;
      logic [31:0] d;
      sel = $urandom_range(0, 9);
      a = (sel < 6) ? CTRL : (sel < 8) ? STAT : 8'($urandom);
      d = $urandom;
      if ($urandom_range(0, 3) != 0) d[2] = 1'b0;
      step($urandom_range(0, 2) == 0, a, d, $urandom_range(0, 1) == 1,
           $urandom_range(0, 4) == 0);
    end
    step(0, CTRL, 0, 0, 0);
    @(negedge clk);
    checkAll();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule